// File: doc/BRIEF.md
# Edge-Triggered External Interrupt Sequencer

This block handles the external interrupt input of a small processor core whose instruction cycle is split into four phases, one clock each, marked by a one-hot phase strobe. The asynchronous pin is brought into the clock domain through two flops. A transition in the direction picked by a polarity input sets a sticky pending flag. The flag stays set until software clears it. The flag, gated by a local enable, raises a wake signal for a sleeping core. When the global enable is also set, the flag becomes a branch request.

The request is sampled only on the first phase of an instruction cycle. On acceptance the block pulses a request to clear the global enable. It lets the instruction in progress complete, then marks the dummy cycles in which the prefetched instruction is thrown away. It pulses a load of the fixed vector address into the program counter, and then flags the instruction cycle in which the vector instruction executes. The count of cycles from acceptance to the vector load is the same whether the interrupted instruction takes one cycle or two. For a two-cycle instruction, its own second cycle takes the place of the first dummy cycle.

Top module: `ext_irq_seq`

## Requirements
- R1: After reset, flag, wake, gie_clr, pc_load_vec, dummy and vec_run are all 0. The pin must be held low while reset is asserted.
- R2: The pin passes two synchronizer flops. With edge_rise=1 a low-to-high transition sets flag, and with edge_rise=0 a high-to-low transition sets it. The flag is set on the third rising clock after the pin changes. A transition in the other direction leaves flag unchanged.
- R3: Once set, flag holds until flag_clr is sampled high, after which it reads 0.
- R4: If flag_clr is high in the same clock as a detected edge, flag is set (the edge wins).
- R5: wake equals flag AND int_en, independent of gie and of the phase.
- R6: A request exists only when flag, int_en and gie are all 1, and it is accepted only while qstb[0] (first phase) is high and no redirect sequence is in progress. Acceptance is a one-clock gie_clr pulse.
- R7: For a one-cycle instruction, dummy is high for the 8 clocks (two instruction cycles) that follow the instruction cycle in which the request was accepted. pc_load_vec pulses 8 clocks after gie_clr. vec_run goes high 13 clocks after gie_clr for one instruction cycle. vector_pc always carries the vector address 4.
- R8: When two_cycle is high at acceptance, dummy is high for only 4 clocks, because the instruction's own second cycle replaces the first dummy cycle. pc_load_vec still pulses 8 clocks after gie_clr.
- R9: While a redirect is in progress, before its vector cycle, no further gie_clr is produced even if the request stays asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one clock per phase |
| rst_n | input | 1 | Active-low synchronous reset |
| qstb | input | 4 | One-hot phase strobe; bit 0 marks the first phase |
| pin | input | 1 | Asynchronous external interrupt pin |
| edge_rise | input | 1 | 1 selects rising edges, 0 selects falling edges |
| int_en | input | 1 | Local enable of this interrupt |
| gie | input | 1 | Global interrupt enable |
| flag_clr | input | 1 | Software clear of the pending flag |
| two_cycle | input | 1 | The instruction in progress takes two cycles |
| flag | output | 1 | Sticky pending flag |
| wake | output | 1 | Wake request for a sleeping core |
| gie_clr | output | 1 | Pulse: request accepted, clear global enable |
| pc_load_vec | output | 1 | Pulse: load vector address into the program counter |
| vector_pc | output | PC_W | Vector address |
| dummy | output | 1 | Inserted dummy instruction cycle |
| vec_run | output | 1 | Instruction cycle executing the vector instruction |

## Verification
The bench builds the block with its default 13-bit program counter and vector address 4. At these values the vector output can be checked against a fixed number, and the full accept, dummy, load and execute chain fits within a few dozen clocks. This lets both the one-cycle and the two-cycle paths run from several phase alignments. A behavioural model follows the pin history and the instruction-cycle count, so the same-clock clear and edge race and both polarities are compared every clock.

// File: rtl/ext_irq_seq.sv
module ext_irq_seq #(
  parameter int PC_W   = 13,
  parameter int VECTOR = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [3:0]      qstb,
  input  logic            pin,
  input  logic            edge_rise,
  input  logic            int_en,
  input  logic            gie,
  input  logic            flag_clr,
  input  logic            two_cycle,
  output logic            flag,
  output logic            wake,
  output logic            gie_clr,
  output logic            pc_load_vec,
  output logic [PC_W-1:0] vector_pc,
  output logic            dummy,
  output logic            vec_run
);

  typedef enum logic [2:0] {S_IDLE, S_CUR, S_D1, S_OWN2, S_D2, S_VEC} st_t;

  logic s1, s2, s3;
  logic edge_hit, q1, open_slot, req, tc_l;
  st_t  st;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      s3 <= 1'b0;
    end else begin
      s1 <= pin;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign edge_hit = edge_rise ? (s2 & ~s3) : (~s2 & s3);

  always_ff @(posedge clk) begin
    if (!rst_n) flag <= 1'b0;
    else        flag <= edge_hit | (flag & ~flag_clr);
  end

  assign q1        = qstb[0];
  assign wake      = flag & int_en;
  assign req       = flag & int_en & gie;
  assign open_slot = (st == S_IDLE) || (st == S_VEC);
  assign gie_clr   = q1 & open_slot & req;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      tc_l <= 1'b0;
    end else if (q1) begin
      case (st)
        S_IDLE, S_VEC: begin
          st <= req ? S_CUR : S_IDLE;
          if (req) tc_l <= two_cycle;
        end
        S_CUR:        st <= tc_l ? S_OWN2 : S_D1;
        S_D1, S_OWN2: st <= S_D2;
        default:      st <= S_VEC;
      endcase
    end
  end

  assign dummy       = (st == S_D1) || (st == S_D2);
  assign pc_load_vec = q1 & ((st == S_D1) || (st == S_OWN2));
  assign vec_run     = (st == S_VEC);
  assign vector_pc   = PC_W'(VECTOR);

  AST_EDGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    edge_hit |=> flag); // R4
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    flag && !flag_clr |=> flag); // R3
  AST_LOAD_THEN_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load_vec |=> dummy && !vec_run); // R7
  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    dummy |-> !gie_clr); // R9
  AST_ACCEPT_THEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    gie_clr |=> !gie_clr && !vec_run); // R6

endmodule

// File: tb/tb_ext_irq_seq.sv
module tb_ext_irq_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] qstb = 4'b0001;
  logic pin = 0, edge_rise = 1, int_en = 0, gie = 0, flag_clr = 0, two_cycle = 0;
  logic flag, wake, gie_clr, pc_load_vec, dummy, vec_run;
  logic [12:0] vector_pc;

  ext_irq_seq dut (.clk(clk), .rst_n(rst_n), .qstb(qstb), .pin(pin), .edge_rise(edge_rise),
    .int_en(int_en), .gie(gie), .flag_clr(flag_clr), .two_cycle(two_cycle), .flag(flag),
    .wake(wake), .gie_clr(gie_clr), .pc_load_vec(pc_load_vec), .vector_pc(vector_pc),
    .dummy(dummy), .vec_run(vec_run));

  always #10 clk = ~clk;

  int errors = 0, checks = 0, cyc = 0, ph = 0;
  int hist[3] = '{0, 0, 0};
  int m_flag = 0, k = 0, m_tc = 0;
  int acc_t, load_t, vr_t, n_dummy, n_clr;
  bit prev_vr = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", tag, cyc, act, exp);
    end
  endtask

  task automatic step();
    int eq1, ex_clr, ex_load, ex_dum;
    @(negedge clk);
    eq1 = (qstb == 4'b0001);
    ex_clr  = (eq1 && (k == 0 || k == 4) && m_flag && int_en && gie) ? 1 : 0;
    ex_load = (eq1 && k == 2) ? 1 : 0;
    ex_dum  = ((k == 2 && !m_tc) || k == 3) ? 1 : 0;
    chk(flag == m_flag, "R3 flag", flag, m_flag);
    chk(wake == (m_flag && int_en), "R5 wake", wake, m_flag && int_en);
    chk(gie_clr == ex_clr, "R6 gie_clr", gie_clr, ex_clr);
    chk(pc_load_vec == ex_load, "R7 pc_load_vec", pc_load_vec, ex_load);
    chk(dummy == ex_dum, "R7 dummy", dummy, ex_dum);
    chk(vec_run == (k == 4), "R7 vec_run", vec_run, k == 4);
    if (gie_clr) begin acc_t = cyc; n_clr++; end
    if (pc_load_vec) load_t = cyc;
    if (vec_run && !prev_vr) vr_t = cyc;
    if (dummy) n_dummy++;
    prev_vr = vec_run;
    @(posedge clk);
    if (!rst_n) begin
      m_flag = 0; k = 0; m_tc = 0; hist = '{0, 0, 0};
    end else begin
      int e, oldf;
      e = edge_rise ? (hist[1] && !hist[2]) : (!hist[1] && hist[2]);
      oldf = m_flag;
      m_flag = (e || (m_flag && !flag_clr)) ? 1 : 0;
      if (eq1) begin
        if ((k == 0 || k == 4) && oldf && int_en && gie) begin k = 1; m_tc = two_cycle; end
        else if (k == 4) k = 0;
        else if (k != 0) k = k + 1;
      end
      hist[2] = hist[1]; hist[1] = hist[0]; hist[0] = pin;
    end
    #1;
    ph = (ph + 1) % 4;
    qstb = 4'b0001 << ph;
    cyc++;
  endtask

  task automatic stepn(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic run_seq(input bit tc);
    n_dummy = 0; n_clr = 0; acc_t = -100; load_t = -200; vr_t = -300;
    two_cycle = tc;
    gie = 1;
    for (int i = 0; i < 40; i++) begin
      step();
      if (load_t >= 0 && gie) gie = 0;
    end
  endtask

  initial begin
    stepn(3);
    rst_n = 1;
    step();
    chk(flag == 0 && dummy == 0 && vec_run == 0 && gie_clr == 0, "R1 reset state", flag, 0);

    edge_rise = 1; pin = 1;
    stepn(2);
    chk(flag == 0, "R2 sync delay", flag, 0);
    stepn(3);
    chk(flag == 1, "R2 rising edge sets", flag, 1);
    chk(wake == 0, "R5 wake gated off", wake, 0);
    int_en = 1;
    step();
    chk(wake == 1, "R5 wake with enable", wake, 1);
    n_clr = 0;
    stepn(8);
    chk(n_clr == 0, "R6 no accept without gie", n_clr, 0);

    pin = 0; stepn(5);
    chk(flag == 1, "R3 flag sticky", flag, 1);
    flag_clr = 1; step(); flag_clr = 0; step();
    chk(flag == 0, "R3 cleared", flag, 0);

    edge_rise = 0; pin = 1; stepn(5);
    chk(flag == 0, "R2 rise ignored when falling selected", flag, 0);
    pin = 0; stepn(5);
    chk(flag == 1, "R2 falling edge sets", flag, 1);

    flag_clr = 1; step(); flag_clr = 0; stepn(2);
    chk(flag == 0, "R3 cleared again", flag, 0);
    pin = 1; stepn(5);
    pin = 0; step(); step();
    flag_clr = 1; step(); flag_clr = 0; step();
    chk(flag == 1, "R4 edge wins over clear", flag, 1);

    for (int r = 0; r < 2; r++) begin
      stepn(r + 1);
      run_seq(0);
      chk(load_t - acc_t == 8, "R7 load latency", load_t - acc_t, 8);
      chk(vr_t - acc_t == 13, "R7 vector exec start", vr_t - acc_t, 13);
      chk(n_dummy == 8, "R7 dummy length", n_dummy, 8);
      chk(vector_pc == 13'd4, "R7 vector address", vector_pc, 4);
      chk(n_clr == 1, "R9 single acceptance", n_clr, 1);
    end

    flag_clr = 1; step(); flag_clr = 0; step();
    pin = 1; stepn(5); pin = 0; stepn(5);
    chk(flag == 1, "R2 new falling edge", flag, 1);
    run_seq(1);
    chk(load_t - acc_t == 8, "R8 load latency two-cycle", load_t - acc_t, 8);
    chk(n_dummy == 4, "R8 dummy length two-cycle", n_dummy, 4);
    chk(n_clr == 1, "R9 single acceptance two-cycle", n_clr, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired: actual=%0d expected=%0d", 20000, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule